// File: doc/BRIEF.md
# Flag-Setting Two-Operand ALU with Register-Amount Shifter

This block is the data-processing stage of a 32-bit integer datapath. It takes a destination operand, a source operand, the current N/Z/C/V condition flags and a 4-bit operation code. It returns a result, a write-enable that says whether the result belongs in the destination register, and the updated flag set. The sixteen operations cover bitwise logic, add and subtract that take the carry into account, negate, compare, compare-negative, test, bit clear, move-not, multiply, and four shifts whose amount comes from a register.

The shifts follow exact carry-out rules when the amount is zero, exactly the word width, or larger than the word width. A multiply-cost output gives an early-termination cycle estimate, based on how many high bytes of the source operand are pure sign extension. The whole unit is combinational, so every opcode, including multiply, produces its result in the same cycle. Register-file access and instruction decode beyond the opcode field belong to the surrounding pipeline.

Top module: `dp_alu`

## Requirements
- R1: The logical opcodes are 0 (AND), 1 (XOR), 0xC (OR), 0xE (dest AND NOT src) and 0xF (NOT src). Each writes its result, and each leaves C and V equal to their inputs.
- R2: Opcode 5 writes dest + src + C. C_out is the carry out of bit 31. V is set when both operands have the same sign and the result's sign differs from it.
- R3: Opcode 6 writes dest − src − (1 − C). C_out is 1 when no borrow occurs. V is set when the operand signs differ and the result's sign differs from the sign of dest.
- R4: Opcode 9 writes 0 − src. Its C and V follow the subtract rules of R3, so C is 1 only for src = 0.
- R5: Opcodes 8 (test: dest AND src), 0xA (compare: dest − src) and 0xB (compare-negative: dest + src) drive write-enable low. They still update N and Z, and compare and compare-negative also update C and V by the rules of R3 and R2. Every other opcode drives write-enable high.
- R6: Shifts (2 left, 3 logical right, 4 arithmetic right, 7 rotate right) take their amount from src bits [7:0] only. An amount of 0 returns dest unchanged and leaves C unchanged. V is never changed by a shift.
- R7: For a left shift by n, n in 1..31 gives C = dest bit (32−n). n = 32 gives 0 with C = dest bit 0. n > 32 gives 0 with C = 0.
- R8: For a logical right shift by n, n in 1..31 gives C = dest bit (n−1). n = 32 gives 0 with C = dest bit 31. n > 32 gives 0 with C = 0.
- R9: For an arithmetic right shift by n, n in 1..31 gives C = dest bit (n−1). n ≥ 32 fills the result with dest bit 31, and C equals that bit.
- R10: For a rotate right, a nonzero amount whose low 5 bits are 0 returns dest unchanged with C = dest bit 31. Any other nonzero amount rotates by (amount mod 32), with C = dest bit (k−1), where k is that reduced amount.
- R11: Opcode 0xD writes the low 32 bits of dest × src and leaves C and V unchanged.
- R12: The multiply-cost output is 1, 2 or 3 when src bits [31:8], [31:16] or [31:24] respectively are all zeros or all ones. The smallest matching count wins. Otherwise the output is 4. It is derived from src for every opcode.
- R13: For every opcode, N_out equals bit 31 of the produced value and Z_out is 1 exactly when that value is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 4 | Operation code (encodings in R1–R11) |
| dst_val | input | 32 | Destination operand, first operand of every operation |
| src_val | input | 32 | Source operand; its low byte is the shift amount, and it is the multiplier |
| n_in | input | 1 | Incoming negative flag |
| z_in | input | 1 | Incoming zero flag |
| c_in | input | 1 | Incoming carry flag |
| v_in | input | 1 | Incoming overflow flag |
| result | output | 32 | Produced value (meaningful when wr_en is high; compare/test present the computed value) |
| wr_en | output | 1 | High when the result should be written to the destination |
| n_out | output | 1 | Updated negative flag |
| z_out | output | 1 | Updated zero flag |
| c_out | output | 1 | Updated carry flag |
| v_out | output | 1 | Updated overflow flag |
| mul_cycles | output | 3 | Early-termination multiply cycle estimate, 1 to 4 |

## Verification
No register lies between the inputs and any output, so the result, write-enable, all four flags and the multiply cost are due in the same cycle as the operands and opcode. The driver applies each stimulus just after a rising edge and queues the expected item. The monitor pops and compares that item at the falling edge half a period later, when the combinational outputs have settled and before the next stimulus arrives. One item is in flight per cycle, so the queue order matches stimulus order exactly.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

    typedef enum logic [3:0] {
        ALU_AND         = 4'h0,
        ALU_XOR         = 4'h1,
        ALU_SHL         = 4'h2,
        ALU_SHR         = 4'h3,
        ALU_SAR         = 4'h4,
        ALU_ADDC        = 4'h5,
        ALU_SUBC        = 4'h6,
        ALU_ROT         = 4'h7,
        ALU_TEST        = 4'h8,
        ALU_NEGATE      = 4'h9,
        ALU_COMPARE     = 4'hA,
        ALU_COMPARE_NEG = 4'hB,
        ALU_OR          = 4'hC,
        ALU_MULT        = 4'hD,
        ALU_CLEAR       = 4'hE,
        ALU_NOT         = 4'hF
    } alu_op_e;

    typedef enum logic [1:0] {
        SK_LEFT  = 2'd0,
        SK_RIGHT = 2'd1,
        SK_ARITH = 2'd2,
        SK_ROT   = 2'd3
    } shift_kind_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } cond_flags_t;

endpackage

// File: rtl/dp_alu_shifter.sv
module dp_alu_shifter
    import dp_alu_pkg::*;
#(
    parameter int W  = 32,
    parameter int AW = 8
) (
    input  logic [W-1:0]  val,
    input  logic [AW-1:0] amt,
    input  shift_kind_e   kind,
    input  logic          carry_in,
    output logic [W-1:0]  res,
    output logic          carry_out
);
    localparam int SHW = $clog2(W);

    // One spare bit on the side the data leaves from holds the last bit out.
    logic [W:0]        left_ext;
    logic [W:0]        right_ext;
    logic signed [W:0] arith_ext;
    logic [SHW-1:0]    rot_k;
    logic [W-1:0]      rotated;

    always_comb begin
        left_ext  = {1'b0, val} << amt;
        right_ext = {val, 1'b0} >> amt;
        arith_ext = $signed({val, 1'b0}) >>> amt;
        rot_k     = amt[SHW-1:0];
        rotated   = (val >> rot_k) | (val << (W - int'(rot_k)));

        if (amt == '0) begin
            res       = val;
            carry_out = carry_in;
        end else begin
            unique case (kind)
                SK_LEFT: begin
                    res       = left_ext[W-1:0];
                    carry_out = left_ext[W];
                end
                SK_RIGHT: begin
                    res       = right_ext[W:1];
                    carry_out = right_ext[0];
                end
                SK_ARITH: begin
                    res       = arith_ext[W:1];
                    carry_out = arith_ext[0];
                end
                SK_ROT: begin
                    // A reduced amount of zero leaves val, so bit W-1 is the carry either way.
                    res       = rotated;
                    carry_out = rotated[W-1];
                end
                default: begin
                    res       = val;
                    carry_out = carry_in;
                end
            endcase
        end
    end

endmodule

// File: rtl/dp_alu_addsub.sv
module dp_alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    logic [W-1:0] y_eff;
    logic [W:0]   wide;

    always_comb begin
        y_eff = sub ? ~y : y;
        wide  = {1'b0, x} + {1'b0, y_eff} + {{W{1'b0}}, cin};
        sum   = wide[W-1:0];
        cout  = wide[W];
        ovf   = (x[W-1] == y_eff[W-1]) && (wide[W-1] != x[W-1]);
    end

endmodule

// File: rtl/dp_alu_mulcost.sv
module dp_alu_mulcost #(
    parameter int W    = 32,
    parameter int GRAN = 8,
    localparam int NG  = W / GRAN,
    localparam int CW  = $clog2(NG + 1)
) (
    input  logic [W-1:0]  mplr,
    output logic [CW-1:0] cycles
);
    logic [NG-1:1] sign_run;

    for (genvar g = 1; g < NG; g++) begin : g_run
        assign sign_run[g] = (&mplr[W-1:g*GRAN]) | ~(|mplr[W-1:g*GRAN]);
    end

    always_comb begin
        cycles = CW'(NG);
        for (int g = NG - 1; g >= 1; g--) begin
            if (sign_run[g]) cycles = CW'(g);
        end
    end

endmodule

// File: rtl/dp_alu.sv
module dp_alu
    import dp_alu_pkg::*;
#(
    parameter int W    = 32,
    parameter int GRAN = 8,
    localparam int CW  = $clog2(W / GRAN + 1)
) (
    input  logic [3:0]    op,
    input  logic [W-1:0]  dst_val,
    input  logic [W-1:0]  src_val,
    input  logic          n_in,
    input  logic          z_in,
    input  logic          c_in,
    input  logic          v_in,
    output logic [W-1:0]  result,
    output logic          wr_en,
    output logic          n_out,
    output logic          z_out,
    output logic          c_out,
    output logic          v_out,
    output logic [CW-1:0] mul_cycles
);
    alu_op_e      opc;
    shift_kind_e  sk;
    logic [W-1:0] sh_res;
    logic         sh_c;
    logic [W-1:0] as_x;
    logic         as_cin;
    logic         as_sub;
    logic [W-1:0] as_sum;
    logic         as_cout;
    logic         as_ovf;
    logic [W-1:0] product;
    cond_flags_t  fl;
    logic [W-1:0] val;
    logic         wr;

    assign opc = alu_op_e'(op);

    // Operand steering for the shared shifter and adder.
    always_comb begin
        unique case (opc)
            ALU_SHR: sk = SK_RIGHT;
            ALU_SAR: sk = SK_ARITH;
            ALU_ROT: sk = SK_ROT;
            default: sk = SK_LEFT;
        endcase

        as_sub = (opc == ALU_SUBC) || (opc == ALU_NEGATE) || (opc == ALU_COMPARE);
        as_x   = (opc == ALU_NEGATE) ? '0 : dst_val;
        unique case (opc)
            ALU_ADDC, ALU_SUBC:      as_cin = c_in;
            ALU_NEGATE, ALU_COMPARE: as_cin = 1'b1;
            default:                 as_cin = 1'b0;
        endcase
    end

    dp_alu_shifter #(.W(W), .AW(8)) u_shift (
        .val       (dst_val),
        .amt       (src_val[7:0]),
        .kind      (sk),
        .carry_in  (c_in),
        .res       (sh_res),
        .carry_out (sh_c)
    );

    dp_alu_addsub #(.W(W)) u_addsub (
        .x    (as_x),
        .y    (src_val),
        .cin  (as_cin),
        .sub  (as_sub),
        .sum  (as_sum),
        .cout (as_cout),
        .ovf  (as_ovf)
    );

    dp_alu_mulcost #(.W(W), .GRAN(GRAN)) u_cost (
        .mplr   (src_val),
        .cycles (mul_cycles)
    );

    assign product = dst_val * src_val;

    // Result and flag selection.
    always_comb begin
        fl  = '{n: n_in, z: z_in, c: c_in, v: v_in};
        val = '0;
        wr  = 1'b1;
        unique case (opc)
            ALU_AND:   val = dst_val & src_val;
            ALU_XOR:   val = dst_val ^ src_val;
            ALU_OR:    val = dst_val | src_val;
            ALU_CLEAR: val = dst_val & ~src_val;
            ALU_NOT:   val = ~src_val;
            ALU_MULT:  val = product;
            ALU_TEST: begin
                val = dst_val & src_val;
                wr  = 1'b0;
            end
            ALU_SHL, ALU_SHR, ALU_SAR, ALU_ROT: begin
                val  = sh_res;
                fl.c = sh_c;
            end
            ALU_ADDC, ALU_SUBC, ALU_NEGATE: begin
                val  = as_sum;
                fl.c = as_cout;
                fl.v = as_ovf;
            end
            ALU_COMPARE, ALU_COMPARE_NEG: begin
                val  = as_sum;
                wr   = 1'b0;
                fl.c = as_cout;
                fl.v = as_ovf;
            end
            default: val = '0;
        endcase
        fl.n = val[W-1];
        fl.z = (val == '0);
    end

    assign result = val;
    assign wr_en  = wr;
    assign n_out  = fl.n;
    assign z_out  = fl.z;
    assign c_out  = fl.c;
    assign v_out  = fl.v;

endmodule

// File: rtl/dp_alu_chk.sv
module dp_alu_chk #(
    parameter int W    = 32,
    parameter int GRAN = 8,
    localparam int NG  = W / GRAN,
    localparam int CW  = $clog2(NG + 1)
) (
    input logic [3:0]    op,
    input logic [W-1:0]  dst_val,
    input logic [W-1:0]  src_val,
    input logic          c_in,
    input logic          v_in,
    input logic [W-1:0]  result,
    input logic          wr_en,
    input logic          n_out,
    input logic          z_out,
    input logic          c_out,
    input logic          v_out,
    input logic [CW-1:0] mul_cycles
);
    logic is_logic;
    logic is_shift;
    logic is_flag_only;

    always_comb begin
        is_logic     = (op == 4'h0) || (op == 4'h1) || (op == 4'hC) ||
                       (op == 4'hE) || (op == 4'hF) || (op == 4'h8);
        is_shift     = (op == 4'h2) || (op == 4'h3) || (op == 4'h4) || (op == 4'h7);
        is_flag_only = (op == 4'h8) || (op == 4'hA) || (op == 4'hB);

        assert_flag_only_no_write_R5: assert (wr_en == !is_flag_only)
            else $error("write-enable wrong for opcode %h", op);

        assert_logic_keeps_cv_R1: assert (!is_logic || (c_out == c_in && v_out == v_in))
            else $error("logical opcode %h altered C or V", op);

        assert_nz_track_result_R13: assert (!wr_en || (n_out == result[W-1] && z_out == (result == '0)))
            else $error("N/Z do not follow the written result");

        assert_zero_amount_passes_R6: assert (!(is_shift && src_val[7:0] == 8'd0) ||
                                              (result == dst_val && c_out == c_in))
            else $error("zero shift amount changed value or carry");

        assert_shift_keeps_v_R6: assert (!is_shift || v_out == v_in)
            else $error("shift altered V");

        assert_mul_cost_range_R12: assert (mul_cycles >= CW'(1) && mul_cycles <= CW'(NG))
            else $error("multiply cost %0d out of range", mul_cycles);

        assert_mul_keeps_cv_R11: assert (op != 4'hD || (c_out == c_in && v_out == v_in))
            else $error("multiply altered C or V");
    end

endmodule

bind dp_alu dp_alu_chk #(.W(W), .GRAN(GRAN)) u_chk (
    .op         (op),
    .dst_val    (dst_val),
    .src_val    (src_val),
    .c_in       (c_in),
    .v_in       (v_in),
    .result     (result),
    .wr_en      (wr_en),
    .n_out      (n_out),
    .z_out      (z_out),
    .c_out      (c_out),
    .v_out      (v_out),
    .mul_cycles (mul_cycles)
);

// File: tb/dp_alu_test.sv
`timescale 1ns/1ps
module dp_alu_test;

    typedef struct {
        logic [31:0] res;
        logic        wr;
        logic [3:0]  nzcv;
        int          cyc;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  op = 4'h0;
    logic [31:0] dst_val = '0;
    logic [31:0] src_val = '0;
    logic        n_in = 1'b0, z_in = 1'b0, c_in = 1'b0, v_in = 1'b0;
    logic [31:0] result;
    logic        wr_en, n_out, z_out, c_out, v_out;
    logic [2:0]  mul_cycles;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    exp_t  exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    dp_alu uut (
        .op(op), .dst_val(dst_val), .src_val(src_val),
        .n_in(n_in), .z_in(z_in), .c_in(c_in), .v_in(v_in),
        .result(result), .wr_en(wr_en),
        .n_out(n_out), .z_out(z_out), .c_out(c_out), .v_out(v_out),
        .mul_cycles(mul_cycles)
    );

    // Independent reference: shifts by bit-stepping loops, borrows by wide compare.
    function automatic exp_t model(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                                   input logic [3:0] f);
        exp_t e;
        logic n, z, c, v;
        logic [32:0] w;
        logic [31:0] r;
        int amt;
        {n, z, c, v} = f;
        r = '0;
        e.wr = 1'b1;
        amt = int'(b[7:0]);
        case (o)
            4'h0: r = a & b;
            4'h1: r = a ^ b;
            4'hC: r = a | b;
            4'hE: r = a & ~b;
            4'hF: r = ~b;
            4'h8: begin r = a & b; e.wr = 1'b0; end
            4'hD: r = a * b;
            4'h5: begin
                w = {1'b0, a} + {1'b0, b} + 33'(c);
                r = w[31:0]; c = w[32];
                v = (a[31] == b[31]) && (r[31] != a[31]);
            end
            4'hB: begin
                w = {1'b0, a} + {1'b0, b};
                r = w[31:0]; c = w[32]; e.wr = 1'b0;
                v = (a[31] == b[31]) && (r[31] != a[31]);
            end
            4'h6, 4'hA, 4'h9: begin
                logic [32:0] lhs, rhs;
                lhs = (o == 4'h9) ? 33'd0 : {1'b0, a};
                rhs = {1'b0, b} + ((o == 4'h6) ? 33'(!c) : 33'd0);
                r = lhs[31:0] - rhs[31:0];
                c = (lhs >= rhs);
                v = (lhs[31] != b[31]) && (r[31] != lhs[31]);
                if (o == 4'hA) e.wr = 1'b0;
            end
            4'h2: begin
                r = a;
                for (int i = 0; i < amt && i < 40; i++) begin c = r[31]; r = r << 1; end
            end
            4'h3: begin
                r = a;
                for (int i = 0; i < amt && i < 40; i++) begin c = r[0]; r = r >> 1; end
            end
            4'h4: begin
                r = a;
                for (int i = 0; i < amt && i < 40; i++) begin c = r[0]; r = {r[31], r[31:1]}; end
            end
            4'h7: begin
                r = a;
                if (amt != 0) begin
                    if (amt % 32 == 0) c = a[31];
                    for (int i = 0; i < amt % 32; i++) begin c = r[0]; r = {r[0], r[31:1]}; end
                end
            end
            default: r = '0;
        endcase
        n = r[31];
        z = (r == 32'd0);
        e.res  = r;
        e.nzcv = {n, z, c, v};
        if (b[31:8] == 24'd0 || b[31:8] == 24'hFFFFFF) e.cyc = 1;
        else if (b[31:16] == 16'd0 || b[31:16] == 16'hFFFF) e.cyc = 2;
        else if (b[31:24] == 8'd0 || b[31:24] == 8'hFF) e.cyc = 3;
        else e.cyc = 4;
        return e;
    endfunction

    task automatic drive(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                         input logic [3:0] f, input string tag);
        @(posedge clk);
        #1;
        op = o; dst_val = a; src_val = b;
        {n_in, z_in, c_in, v_in} = f;
        exp_q.push_back(model(o, a, b, f));
        tag_q.push_back(tag);
    endtask

    // Monitor: outputs are combinational, compared half a period after the stimulus.
    always @(negedge clk) begin
        if (!rst && exp_q.size() > 0) begin
            exp_t  e;
            string t;
            logic  bad;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            bad = (wr_en !== e.wr) || ({n_out, z_out, c_out, v_out} !== e.nzcv) ||
                  (int'(mul_cycles) != e.cyc) || (e.wr && result !== e.res);
            if (bad) begin
                errors++;
                $display("FAIL %s: actual res=%h wr=%b nzcv=%b cyc=%0d expected res=%h wr=%b nzcv=%b cyc=%0d",
                         t, result, wr_en, {n_out, z_out, c_out, v_out}, mul_cycles,
                         e.res, e.wr, e.nzcv, e.cyc);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // Idle state after reset: all-zero inputs, opcode 0.
        drive(4'h0, 32'h0, 32'h0, 4'b0000, "R1 idle");
        // R1 logical opcodes, C and V preserved
        drive(4'h0, 32'hF0F0_1234, 32'hFF00_FF00, 4'b0011, "R1 and");
        drive(4'h1, 32'hAAAA_5555, 32'hFFFF_0000, 4'b0010, "R1 xor");
        drive(4'hC, 32'h8000_0000, 32'h0000_0001, 4'b0001, "R1 or");
        drive(4'hE, 32'hFFFF_FFFF, 32'h0F0F_0F0F, 4'b0000, "R1 clear");
        drive(4'hF, 32'h1234_5678, 32'hFFFF_FFFF, 4'b1011, "R1 not zero");
        // R2 add with carry
        drive(4'h5, 32'h7FFF_FFFF, 32'h0, 4'b0010, "R2 overflow via carry");
        drive(4'h5, 32'hFFFF_FFFF, 32'h1, 4'b0000, "R2 carry out zero");
        drive(4'h5, 32'h8000_0000, 32'h8000_0000, 4'b0000, "R2 neg overflow");
        // R3 subtract with carry
        drive(4'h6, 32'd5, 32'd3, 4'b0010, "R3 no borrow");
        drive(4'h6, 32'd3, 32'd3, 4'b0000, "R3 borrow in");
        drive(4'h6, 32'h8000_0000, 32'd1, 4'b0010, "R3 overflow");
        // R4 negate
        drive(4'h9, 32'hDEAD_BEEF, 32'd0, 4'b0000, "R4 zero");
        drive(4'h9, 32'h0, 32'd1, 4'b0010, "R4 one");
        drive(4'h9, 32'h0, 32'h8000_0000, 4'b0000, "R4 min");
        // R5 flag-only operations
        drive(4'h8, 32'hF0, 32'h0F, 4'b0011, "R5 test zero");
        drive(4'hA, 32'd9, 32'd9, 4'b0000, "R5 compare equal");
        drive(4'hA, 32'd1, 32'd2, 4'b0010, "R5 compare less");
        drive(4'hB, 32'hFFFF_FFFF, 32'd1, 4'b0000, "R5 compare neg");
        // R6 zero amount, upper source bits ignored
        drive(4'h2, 32'h8000_0001, 32'h0000_0100, 4'b0010, "R6 left zero amt");
        drive(4'h3, 32'h8000_0001, 32'hFFFF_FF00, 4'b0001, "R6 right zero amt");
        drive(4'h7, 32'h1234_5678, 32'h0, 4'b0000, "R6 rotate zero amt");
        // R7 left shift
        drive(4'h2, 32'h4000_0001, 32'd1, 4'b0000, "R7 by 1");
        drive(4'h2, 32'h0000_0003, 32'd31, 4'b0000, "R7 by 31");
        drive(4'h2, 32'h0000_0001, 32'h0000_0120, 4'b0000, "R7 by 32");
        drive(4'h2, 32'hFFFF_FFFF, 32'd33, 4'b0010, "R7 by 33");
        drive(4'h2, 32'hFFFF_FFFF, 32'd255, 4'b0010, "R7 by 255");
        // R8 logical right shift
        drive(4'h3, 32'h8000_0002, 32'd2, 4'b0000, "R8 by 2");
        drive(4'h3, 32'h8000_0000, 32'd32, 4'b0000, "R8 by 32");
        drive(4'h3, 32'hFFFF_FFFF, 32'd40, 4'b0010, "R8 by 40");
        // R9 arithmetic right shift
        drive(4'h4, 32'h8000_0008, 32'd4, 4'b0000, "R9 neg by 4");
        drive(4'h4, 32'h8000_0000, 32'd32, 4'b0000, "R9 neg by 32");
        drive(4'h4, 32'h9000_0000, 32'd200, 4'b0000, "R9 neg by 200");
        drive(4'h4, 32'h7FFF_FFFF, 32'd40, 4'b0010, "R9 pos by 40");
        // R10 rotate right
        drive(4'h7, 32'h0000_00F1, 32'd4, 4'b0000, "R10 by 4");
        drive(4'h7, 32'h8000_0000, 32'd32, 4'b0000, "R10 by 32");
        drive(4'h7, 32'h7000_0000, 32'd64, 4'b0010, "R10 by 64");
        drive(4'h7, 32'h0000_0008, 32'd36, 4'b0000, "R10 by 36");
        // R11 multiply
        drive(4'hD, 32'd7, 32'd6, 4'b0011, "R11 small");
        drive(4'hD, 32'h0001_0000, 32'h0001_0000, 4'b0000, "R11 wraps to zero");
        drive(4'hD, 32'hFFFF_FFFF, 32'd3, 4'b0000, "R11 negative");
        // R12 multiply cost
        drive(4'hD, 32'd2, 32'hFFFF_FF80, 4'b0000, "R12 cost 1 ones");
        drive(4'hD, 32'd2, 32'h0000_1234, 4'b0000, "R12 cost 2");
        drive(4'hD, 32'd2, 32'h0012_3456, 4'b0000, "R12 cost 3");
        drive(4'hD, 32'd2, 32'hFF80_0000, 4'b0000, "R12 cost 3 ones");
        drive(4'hD, 32'd2, 32'h1234_5678, 4'b0000, "R12 cost 4");
        drive(4'h0, 32'd0, 32'h7FFF_0000, 4'b0000, "R12 cost on non-multiply");
        // R13 N and Z over varied opcodes
        drive(4'h1, 32'h8000_0000, 32'h0, 4'b0100, "R13 negative");
        drive(4'h5, 32'hFFFF_FFFE, 32'd1, 4'b0010, "R13 zero");
        repeat (3) @(posedge clk);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule